// File: doc/BRIEF.md
# DIMM Thermal Status and Interrupt Unit

This unit watches a temperature-or-power reading for each DIMM of a two-channel, two-DIMM-per-channel memory subsystem. Each DIMM has its own WARM and HOT thresholds, and the unit sorts every DIMM into one of three levels against them. It then forms two chip-wide values: the hottest status and the highest reading. An external thermal status can be folded into the hottest status. The hottest status drives a coded request for double refresh rate. The hottest status and the highest reading together produce a set of interrupt events.

Configuration lives in a small word-addressed register file. A sticky lock bit in that file freezes the thresholds and the throttle budgets until the next reset. Each interrupt event is a one-cycle pulse. The pulse also sets a sticky status bit, and software clears that bit by writing 1 to it. Outputs from the unit's registers are valid on the clock edge that samples the inputs. A configuration write takes effect one edge later.

Top module: `dimm_thermal_unit`

## Requirements
- R1: DIMM i reads byte i of `dimm_val`. Its level is HOT (code 2) when the reading is >= its HOT threshold. Otherwise it is WARM (code 1) when the reading is >= its WARM threshold, and COLD (code 0) in all other cases. The level appears at `dimm_status_o[2i+1:2i]` after one clock edge. Code 3 never appears.
- R2: `hot_temp_o` is the largest of the four readings. With a computed mode on and the external input off, `hot_status_o` is the largest per-DIMM level.
- R3: `loop_mode_o` reads 2 (closed loop) when the closed enable is set, whether or not the open enable is set. It reads 1 (open loop) when only the open enable is set, and 0 when neither is set.
- R4: With the external enable set and a computed mode on, the hottest status is the larger of the computed level and the external level. With no computed mode on, the hottest status is the external level. External code 3 counts as HOT.
- R5: With closed, open and external all disabled, `hot_status_o` is COLD and neither status event fires.
- R6: Event bit 0 (WARM) pulses when the hottest status moves from COLD to WARM or HOT. Event bit 1 (HOT) pulses when it moves from below HOT to HOT. A move straight from COLD to HOT pulses both. A falling status produces no event.
- R7: Event bits 2 and 3 pulse when the highest reading crosses policy threshold 1 or 2 in either direction, where "above" means >=. They fire only in closed-loop mode.
- R8: Refresh mode field values: 0 gives no request; 1 requests while the hottest status is WARM or HOT; 2 requests only while it is HOT; 3 gives no request and sets `refresh_mode_err_o`.
- R9: Event bit 4 pulses on each rising edge of the double-refresh request.
- R10: Each event also requires its bit in the enable register (address 1, bits [4:0]). An event sets its sticky bit in address 2. Writing 1 to a sticky bit clears it, and a set in the same cycle wins over the clear. `irq_o` is the OR of the sticky bits.
- R11: Register map. Address 0 is control: [0] closed, [1] open, [2] external, [4:3] refresh mode, [8] lock. Address 3 holds policy thresholds: [7:0] threshold 1, [15:8] threshold 2. Addresses 4, 5, 6 and 7 hold the WARM thresholds, HOT thresholds, WARM budgets and HOT budgets, with DIMM i at bits [8i+7:8i]. Writing 1 to control bit 8 sets the lock. A write of 0 to that bit leaves it set, and only reset clears it. While the lock is set, writes to addresses 4 to 7 are ignored.
- R12: After reset, every threshold and budget byte is 0xFF and all other registers read 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| dimm_val | input | 32 | Per-DIMM reading, DIMM i in byte i |
| ext_status | input | 2 | External thermal level |
| dimm_status_o | output | 8 | Per-DIMM level, 2 bits per DIMM |
| hot_status_o | output | 2 | Merged hottest level |
| hot_temp_o | output | 8 | Highest reading |
| refresh_2x_o | output | 1 | Double-refresh request |
| refresh_mode_err_o | output | 1 | Refresh mode field holds the illegal code |
| loop_mode_o | output | 2 | Active computed mode |
| evt_o | output | 5 | One-cycle event pulses |
| irq_o | output | 1 | Any sticky event bit set |
| warm_budget_o | output | 32 | WARM throttle budgets |
| hot_budget_o | output | 32 | HOT throttle budgets |

## Verification
Every level, reading, refresh request and event pulse is registered once. Each one is therefore due on the first rising edge after the inputs are driven. The sticky bits set on that same edge. The bench drives inputs on a falling edge and samples on the next falling edge, so exactly one rising edge separates stimulus from check. A configuration write takes one edge to land. For that reason an idle edge follows every mode change before any level or refresh result is compared. The pulse nature of the events is checked by sampling one further edge later and expecting zero.

// File: rtl/dtu_pkg.sv
package dtu_pkg;

    localparam int TW      = 8;
    localparam int REG_W   = 32;
    localparam int NUM_EVT = 5;

    localparam int EV_WARM = 0;
    localparam int EV_HOT  = 1;
    localparam int EV_PF1  = 2;
    localparam int EV_PF2  = 3;
    localparam int EV_REF  = 4;

    localparam logic [1:0] ST_COLD = 2'd0;
    localparam logic [1:0] ST_WARM = 2'd1;
    localparam logic [1:0] ST_HOT  = 2'd2;

    typedef enum logic [1:0] {
        LOOP_NONE   = 2'd0,
        LOOP_OPEN   = 2'd1,
        LOOP_CLOSED = 2'd2
    } loop_mode_e;

    localparam logic [3:0] A_CTRL    = 4'd0;
    localparam logic [3:0] A_IRQEN   = 4'd1;
    localparam logic [3:0] A_IRQST   = 4'd2;
    localparam logic [3:0] A_PFTHR   = 4'd3;
    localparam logic [3:0] A_WARMTHR = 4'd4;
    localparam logic [3:0] A_HOTTHR  = 4'd5;
    localparam logic [3:0] A_WARMBUD = 4'd6;
    localparam logic [3:0] A_HOTBUD  = 4'd7;

    typedef struct packed {
        logic               closed_en;
        logic               open_en;
        logic               ext_en;
        logic [1:0]         ref_mode;
        logic               lock;
        logic [NUM_EVT-1:0] irq_en;
        logic [NUM_EVT-1:0] irq_stat;
        logic [TW-1:0]      pf_thr1;
        logic [TW-1:0]      pf_thr2;
        logic [REG_W-1:0]   warm_thr;
        logic [REG_W-1:0]   hot_thr;
        logic [REG_W-1:0]   warm_bud;
        logic [REG_W-1:0]   hot_bud;
    } cfg_t;

endpackage

// File: rtl/dtu_cfg_regs.sv
module dtu_cfg_regs
    import dtu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [3:0]           addr,
    input  logic [REG_W-1:0]     wdata,
    input  logic [NUM_EVT-1:0]   evt_set,
    output cfg_t                 cfg_o,
    output logic [REG_W-1:0]     rdata
);

    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we) begin
            case (addr)
                A_CTRL: begin
                    c_d.closed_en = wdata[0];
                    c_d.open_en   = wdata[1];
                    c_d.ext_en    = wdata[2];
                    c_d.ref_mode  = wdata[4:3];
                    c_d.lock      = c_q.lock | wdata[8];
                end
                A_IRQEN: c_d.irq_en   = wdata[NUM_EVT-1:0];
                A_IRQST: c_d.irq_stat = c_q.irq_stat & ~wdata[NUM_EVT-1:0];
                A_PFTHR: begin
                    c_d.pf_thr1 = wdata[TW-1:0];
                    c_d.pf_thr2 = wdata[2*TW-1:TW];
                end
                A_WARMTHR: if (!c_q.lock) c_d.warm_thr = wdata;
                A_HOTTHR:  if (!c_q.lock) c_d.hot_thr  = wdata;
                A_WARMBUD: if (!c_q.lock) c_d.warm_bud = wdata;
                A_HOTBUD:  if (!c_q.lock) c_d.hot_bud  = wdata;
                default: ;
            endcase
        end
        // a new event outranks a same-cycle clear
        c_d.irq_stat = c_d.irq_stat | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q          <= '0;
            c_q.pf_thr1  <= '1;
            c_q.pf_thr2  <= '1;
            c_q.warm_thr <= '1;
            c_q.hot_thr  <= '1;
            c_q.warm_bud <= '1;
            c_q.hot_bud  <= '1;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[0]   = c_q.closed_en;
                rdata[1]   = c_q.open_en;
                rdata[2]   = c_q.ext_en;
                rdata[4:3] = c_q.ref_mode;
                rdata[8]   = c_q.lock;
            end
            A_IRQEN:   rdata[NUM_EVT-1:0] = c_q.irq_en;
            A_IRQST:   rdata[NUM_EVT-1:0] = c_q.irq_stat;
            A_PFTHR:   rdata[2*TW-1:0]    = {c_q.pf_thr2, c_q.pf_thr1};
            A_WARMTHR: rdata = c_q.warm_thr;
            A_HOTTHR:  rdata = c_q.hot_thr;
            A_WARMBUD: rdata = c_q.warm_bud;
            A_HOTBUD:  rdata = c_q.hot_bud;
            default:   rdata = '0;
        endcase
    end

    assign cfg_o = c_q;

    // R11: the lock survives every write
    p_lock_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.lock |=> c_q.lock);

    // R11: locked fields do not move
    p_locked_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.lock |=> ($stable(c_q.warm_thr) && $stable(c_q.hot_thr)
                      && $stable(c_q.warm_bud) && $stable(c_q.hot_bud)));

    // R10: an event always lands in the sticky bits
    p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((c_q.irq_stat & $past(evt_set)) == $past(evt_set)));

endmodule

// File: rtl/dtu_classify.sv
module dtu_classify
    import dtu_pkg::*;
#(
    parameter int NUM_DIMM = 4
) (
    input  logic [NUM_DIMM*TW-1:0] vals,
    input  logic [REG_W-1:0]       warm_thr,
    input  logic [REG_W-1:0]       hot_thr,
    output logic [2*NUM_DIMM-1:0]  dimm_st,
    output logic [1:0]             max_st,
    output logic [TW-1:0]          max_val
);

    localparam int THR_USED = NUM_DIMM * TW;

    logic unused_thr;
    assign unused_thr = (THR_USED < REG_W) ? (^warm_thr ^ ^hot_thr) : 1'b0;

    for (genvar g = 0; g < NUM_DIMM; g++) begin : g_dimm
        logic [TW-1:0] v, w, h;
        assign v = vals[g*TW +: TW];
        assign w = warm_thr[g*TW +: TW];
        assign h = hot_thr[g*TW +: TW];
        always_comb begin
            if (v >= h)      dimm_st[2*g +: 2] = ST_HOT;
            else if (v >= w) dimm_st[2*g +: 2] = ST_WARM;
            else             dimm_st[2*g +: 2] = ST_COLD;
        end
    end

    always_comb begin
        max_st  = ST_COLD;
        max_val = '0;
        for (int i = 0; i < NUM_DIMM; i++) begin
            if (dimm_st[2*i +: 2] > max_st)  max_st  = dimm_st[2*i +: 2];
            if (vals[i*TW +: TW] > max_val)  max_val = vals[i*TW +: TW];
        end
    end

endmodule

// File: rtl/dtu_events.sv
module dtu_events
    import dtu_pkg::*;
#(
    parameter int NUM_DIMM = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  closed_en,
    input  logic                  open_en,
    input  logic                  ext_en,
    input  logic [1:0]            ref_mode,
    input  logic [NUM_EVT-1:0]    irq_en,
    input  logic [TW-1:0]         pf_thr1,
    input  logic [TW-1:0]         pf_thr2,
    input  logic [2*NUM_DIMM-1:0] dimm_st_i,
    input  logic [1:0]            max_st_i,
    input  logic [TW-1:0]         max_val_i,
    input  logic [1:0]            ext_st_i,
    output logic [2*NUM_DIMM-1:0] dimm_st_o,
    output logic [1:0]            hot_st_o,
    output logic [TW-1:0]         hot_temp_o,
    output logic                  refresh_o,
    output logic                  ref_err_o,
    output logic [1:0]            loop_o,
    output logic [NUM_EVT-1:0]    evt_o,
    output logic [NUM_EVT-1:0]    evt_set_o
);

    typedef struct packed {
        logic [2*NUM_DIMM-1:0] dimm_st;
        logic [1:0]            st;
        logic [TW-1:0]         temp;
        logic                  refr;
        logic                  above1;
        logic                  above2;
        logic [NUM_EVT-1:0]    evt;
    } state_t;

    state_t     s_d, s_q;
    loop_mode_e loop;
    logic [1:0] ext_v;
    logic [1:0] merged;

    always_comb begin
        s_d = s_q;

        if (closed_en)    loop = LOOP_CLOSED;
        else if (open_en) loop = LOOP_OPEN;
        else              loop = LOOP_NONE;

        ext_v = (ext_st_i == 2'b11) ? ST_HOT : ext_st_i;

        if (loop != LOOP_NONE)
            merged = (ext_en && (ext_v > max_st_i)) ? ext_v : max_st_i;
        else if (ext_en)
            merged = ext_v;
        else
            merged = ST_COLD;

        s_d.dimm_st = dimm_st_i;
        s_d.st      = merged;
        s_d.temp    = max_val_i;

        case (ref_mode)
            2'b01:   s_d.refr = (merged != ST_COLD);
            2'b10:   s_d.refr = (merged == ST_HOT);
            default: s_d.refr = 1'b0;
        endcase

        s_d.above1 = (max_val_i >= pf_thr1);
        s_d.above2 = (max_val_i >= pf_thr2);

        s_d.evt          = '0;
        s_d.evt[EV_WARM] = irq_en[EV_WARM] && (s_q.st == ST_COLD) && (merged != ST_COLD);
        s_d.evt[EV_HOT]  = irq_en[EV_HOT]  && (s_q.st != ST_HOT)  && (merged == ST_HOT);
        s_d.evt[EV_PF1]  = irq_en[EV_PF1]  && (loop == LOOP_CLOSED) && (s_d.above1 != s_q.above1);
        s_d.evt[EV_PF2]  = irq_en[EV_PF2]  && (loop == LOOP_CLOSED) && (s_d.above2 != s_q.above2);
        s_d.evt[EV_REF]  = irq_en[EV_REF]  && s_d.refr && !s_q.refr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dimm_st_o  = s_q.dimm_st;
    assign hot_st_o   = s_q.st;
    assign hot_temp_o = s_q.temp;
    assign refresh_o  = s_q.refr;
    assign ref_err_o  = (ref_mode == 2'b11);
    assign loop_o     = loop;
    assign evt_o      = s_q.evt;
    assign evt_set_o  = s_d.evt;

    // R6: WARM event only on a rise out of COLD
    p_warm_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.evt[EV_WARM] |-> (s_q.st != ST_COLD && $past(s_q.st) == ST_COLD));

    // R6: HOT event only on arrival at HOT
    p_hot_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.evt[EV_HOT] |-> (s_q.st == ST_HOT && $past(s_q.st) != ST_HOT));

    // R7: policy-threshold events need closed loop
    p_pf_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.evt[EV_PF1] || s_q.evt[EV_PF2]) |-> $past(closed_en));

    // R5: all sources off keeps status quiet
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!closed_en && !open_en && !ext_en) |=>
            (s_q.st == ST_COLD && !s_q.evt[EV_WARM] && !s_q.evt[EV_HOT]));

    // R8: the illegal code never requests refresh
    p_illegal_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_mode == 2'b11) |=> !s_q.refr);

    // R9: refresh event only on a request edge
    p_ref_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.evt[EV_REF] |-> $rose(s_q.refr));

    // R1: no per-DIMM level ever carries code 3
    for (genvar g = 0; g < NUM_DIMM; g++) begin : g_chk
        p_level_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.dimm_st[2*g +: 2] != 2'b11);
    end

endmodule

// File: rtl/dimm_thermal_unit.sv
module dimm_thermal_unit
    import dtu_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int DIMM_PER_CH = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [3:0]                      cfg_addr,
    input  logic [31:0]                     cfg_wdata,
    output logic [31:0]                     cfg_rdata,
    input  logic [NUM_CH*DIMM_PER_CH*8-1:0] dimm_val,
    input  logic [1:0]                      ext_status,
    output logic [NUM_CH*DIMM_PER_CH*2-1:0] dimm_status_o,
    output logic [1:0]                      hot_status_o,
    output logic [7:0]                      hot_temp_o,
    output logic                            refresh_2x_o,
    output logic                            refresh_mode_err_o,
    output logic [1:0]                      loop_mode_o,
    output logic [4:0]                      evt_o,
    output logic                            irq_o,
    output logic [31:0]                     warm_budget_o,
    output logic [31:0]                     hot_budget_o
);

    localparam int NUM_DIMM = NUM_CH * DIMM_PER_CH;

    cfg_t                  cfg;
    logic [NUM_EVT-1:0]    evt_set;
    logic [2*NUM_DIMM-1:0] raw_st;
    logic [1:0]            raw_max_st;
    logic [TW-1:0]         raw_max_val;

    dtu_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .evt_set (evt_set),
        .cfg_o   (cfg),
        .rdata   (cfg_rdata)
    );

    dtu_classify #(.NUM_DIMM(NUM_DIMM)) u_class (
        .vals     (dimm_val),
        .warm_thr (cfg.warm_thr),
        .hot_thr  (cfg.hot_thr),
        .dimm_st  (raw_st),
        .max_st   (raw_max_st),
        .max_val  (raw_max_val)
    );

    dtu_events #(.NUM_DIMM(NUM_DIMM)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .closed_en  (cfg.closed_en),
        .open_en    (cfg.open_en),
        .ext_en     (cfg.ext_en),
        .ref_mode   (cfg.ref_mode),
        .irq_en     (cfg.irq_en),
        .pf_thr1    (cfg.pf_thr1),
        .pf_thr2    (cfg.pf_thr2),
        .dimm_st_i  (raw_st),
        .max_st_i   (raw_max_st),
        .max_val_i  (raw_max_val),
        .ext_st_i   (ext_status),
        .dimm_st_o  (dimm_status_o),
        .hot_st_o   (hot_status_o),
        .hot_temp_o (hot_temp_o),
        .refresh_o  (refresh_2x_o),
        .ref_err_o  (refresh_mode_err_o),
        .loop_o     (loop_mode_o),
        .evt_o      (evt_o),
        .evt_set_o  (evt_set)
    );

    assign irq_o         = |cfg.irq_stat;
    assign warm_budget_o = cfg.warm_bud;
    assign hot_budget_o  = cfg.hot_bud;

endmodule

// File: tb/dimm_thermal_unit_tb.sv
`timescale 1ns/1ps
module dimm_thermal_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] dimm_val;
    logic [1:0]  ext_status;
    logic [7:0]  dimm_status_o;
    logic [1:0]  hot_status_o;
    logic [7:0]  hot_temp_o;
    logic        refresh_2x_o;
    logic        refresh_mode_err_o;
    logic [1:0]  loop_mode_o;
    logic [4:0]  evt_o;
    logic        irq_o;
    logic [31:0] warm_budget_o;
    logic [31:0] hot_budget_o;

    int n_cmp = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dimm_thermal_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dimm_val(dimm_val),
        .ext_status(ext_status), .dimm_status_o(dimm_status_o),
        .hot_status_o(hot_status_o), .hot_temp_o(hot_temp_o),
        .refresh_2x_o(refresh_2x_o), .refresh_mode_err_o(refresh_mode_err_o),
        .loop_mode_o(loop_mode_o), .evt_o(evt_o), .irq_o(irq_o),
        .warm_budget_o(warm_budget_o), .hot_budget_o(hot_budget_o)
    );

    typedef struct packed {
        logic [31:0] val;
        logic [7:0]  dst;
        logic [1:0]  hs;
        logic [7:0]  tmp;
    } vec_t;

    // thresholds: warm 0x50403020, hot 0x90807060 (DIMM0 in low byte)
    localparam vec_t VECS [9] = '{
        '{32'h00000000, 8'h00, 2'd0, 8'h00},
        '{32'h0000001F, 8'h00, 2'd0, 8'h1F},
        '{32'h00000020, 8'h01, 2'd1, 8'h20},
        '{32'h00007000, 8'h08, 2'd2, 8'h70},
        '{32'h4F3F2F1F, 8'h00, 2'd0, 8'h4F},
        '{32'h50403020, 8'h55, 2'd1, 8'h50},
        '{32'h90807060, 8'hAA, 2'd2, 8'h90},
        '{32'hFF006000, 8'h84, 2'd2, 8'hFF},
        '{32'h8F7F6F5F, 8'h55, 2'd1, 8'h8F}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        cfg_we = 1'b0; cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic drive(input logic [31:0] v);
        dimm_val = v;
        @(negedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        dimm_val = '0; ext_status = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R12 reset state
        rd(4'd0, r); chk("R12 ctrl reset", r, 32'h0);
        rd(4'd4, r); chk("R12 warm thr reset", r, 32'hFFFFFFFF);
        rd(4'd3, r); chk("R12 policy thr reset", r, 32'h0000FFFF);
        rd(4'd9, r); chk("R12 unmapped read", r, 32'h0);
        chk("R12 hottest reset", {30'b0, hot_status_o}, 32'd0);
        chk("R12 irq reset", {31'b0, irq_o}, 32'd0);

        // R1 R2 vector table, closed loop only
        wr(4'd4, 32'h50403020);
        wr(4'd5, 32'h90807060);
        wr(4'd0, 32'h1);
        foreach (VECS[i]) begin
            drive(VECS[i].val);
            chk("R1 per-DIMM level", {24'b0, dimm_status_o}, {24'b0, VECS[i].dst});
            chk("R2 hottest level", {30'b0, hot_status_o}, {30'b0, VECS[i].hs});
            chk("R2 highest reading", {24'b0, hot_temp_o}, {24'b0, VECS[i].tmp});
        end

        // R3 mode priority
        wr(4'd0, 32'h3); chk("R3 both set closed wins", {30'b0, loop_mode_o}, 32'd2);
        wr(4'd0, 32'h2); chk("R3 open only", {30'b0, loop_mode_o}, 32'd1);
        wr(4'd0, 32'h0); chk("R3 none", {30'b0, loop_mode_o}, 32'd0);

        // R5 everything off
        wr(4'd1, 32'h1F);
        wr(4'd2, 32'h1F);
        drive(32'h0);
        drive(32'h90807060);
        chk("R5 hottest stays cold", {30'b0, hot_status_o}, 32'd0);
        chk("R5 no event", {27'b0, evt_o}, 32'd0);
        rd(4'd2, r); chk("R5 no sticky", r, 32'h0);

        // R6 status events
        drive(32'h0);
        wr(4'd1, 32'h03);
        wr(4'd0, 32'h1);
        idle();
        wr(4'd2, 32'h1F);
        drive(32'h00000020);
        chk("R6 warm event", {27'b0, evt_o}, 32'h01);
        idle();
        chk("R6 warm pulse one cycle", {27'b0, evt_o}, 32'h00);
        rd(4'd2, r); chk("R10 sticky warm", r, 32'h01);
        chk("R10 irq set", {31'b0, irq_o}, 32'd1);
        drive(32'h00000060);
        chk("R6 hot event", {27'b0, evt_o}, 32'h02);
        drive(32'h0);
        chk("R6 falling no event", {27'b0, evt_o}, 32'h00);
        drive(32'h00000060);
        chk("R6 cold to hot both", {27'b0, evt_o}, 32'h03);

        // R10 write-one-to-clear
        wr(4'd2, 32'h01);
        rd(4'd2, r); chk("R10 clear one bit", r, 32'h02);
        wr(4'd2, 32'h02);
        rd(4'd2, r); chk("R10 clear all", r, 32'h00);
        chk("R10 irq cleared", {31'b0, irq_o}, 32'd0);

        // R4 external merge
        wr(4'd0, 32'h5);
        ext_status = 2'd1;
        drive(32'h0);
        chk("R4 external hotter", {30'b0, hot_status_o}, 32'd1);
        ext_status = 2'd1;
        drive(32'h90807060);
        chk("R4 computed hotter", {30'b0, hot_status_o}, 32'd2);
        wr(4'd0, 32'h4);
        ext_status = 2'd0;
        drive(32'h90807060);
        chk("R4 external only", {30'b0, hot_status_o}, 32'd0);
        ext_status = 2'd3;
        drive(32'h90807060);
        chk("R4 code 3 as hot", {30'b0, hot_status_o}, 32'd2);
        ext_status = 2'd0;

        // R7 policy thresholds
        wr(4'd1, 32'h0C);
        wr(4'd3, 32'h00008040);
        wr(4'd0, 32'h1);
        drive(32'h0);
        idle();
        wr(4'd2, 32'h1F);
        drive(32'h00000040);
        chk("R7 rising crossing thr1", {27'b0, evt_o}, 32'h04);
        drive(32'h0000003F);
        chk("R7 falling crossing thr1", {27'b0, evt_o}, 32'h04);
        drive(32'h00000080);
        chk("R7 crossing both", {27'b0, evt_o}, 32'h0C);
        wr(4'd0, 32'h2);
        idle();
        drive(32'h0);
        chk("R7 open loop silent", {27'b0, evt_o}, 32'h00);

        // R8 R9 refresh coding
        wr(4'd1, 32'h10);
        wr(4'd0, 32'h09);
        drive(32'h0);
        chk("R8 mode1 cold no request", {31'b0, refresh_2x_o}, 32'd0);
        drive(32'h00000020);
        chk("R8 mode1 warm requests", {31'b0, refresh_2x_o}, 32'd1);
        chk("R9 refresh event", {27'b0, evt_o}, 32'h10);
        wr(4'd0, 32'h11);
        idle();
        chk("R8 mode2 warm no request", {31'b0, refresh_2x_o}, 32'd0);
        drive(32'h00000060);
        chk("R8 mode2 hot requests", {31'b0, refresh_2x_o}, 32'd1);
        chk("R9 refresh event mode2", {27'b0, evt_o}, 32'h10);
        wr(4'd0, 32'h19);
        idle();
        chk("R8 illegal flagged", {31'b0, refresh_mode_err_o}, 32'd1);
        chk("R8 illegal no request", {31'b0, refresh_2x_o}, 32'd0);

        // R11 lock
        wr(4'd6, 32'h12345678);
        rd(4'd6, r); chk("R11 budget write before lock", r, 32'h12345678);
        chk("R11 budget port", warm_budget_o, 32'h12345678);
        wr(4'd0, 32'h101);
        wr(4'd4, 32'h01010101);
        rd(4'd4, r); chk("R11 locked threshold ignored", r, 32'h50403020);
        wr(4'd6, 32'h0);
        rd(4'd6, r); chk("R11 locked budget ignored", r, 32'h12345678);
        wr(4'd0, 32'h001);
        rd(4'd0, r); chk("R11 lock not cleared by write", r, 32'h101);
        wr(4'd3, 32'h00001234);
        rd(4'd3, r); chk("R11 policy thr not locked", r, 32'h1234);
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        idle();
        rd(4'd0, r); chk("R11 reset clears lock", r, 32'h0);
        rd(4'd4, r); chk("R12 threshold after reset", r, 32'hFFFFFFFF);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

endmodule